// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous static memory on a shared data bus that accepts one command on every clock and never needs an idle cycle when the bus changes direction. A command is sampled together with its address. A read returns its word from an output register one edge later. A write takes its data two edges after its address, so a read and a write may follow each other in any order at full rate. The storage holds 256 words of four 9-bit lanes (8 data bits and one parity bit per lane), and byte-lane selects pick which lanes a write changes.

The block has no valid/ready handshake. Every enabled edge is a command slot, and the only back-pressure is the active-low clock enable. Holding it high freezes every register, the command pipeline included, as if the previous cycle were extended. Burst addresses come from an outside sequencer: with the load strobe high, the address pins give the next beat and the access type of the burst is kept. The bus drive enable `bus_drive` is meant to control the three-state buffers of the shared data bus.

Top module: `nbl_sram`

## Requirements
- R1: While `clk_en_n` is high at a rising edge, no register changes: `rdata`, the pending writes and the burst state hold, and a write whose data phase is stalled takes its data at the next enabled edge.
- R2: A new access starts at an enabled edge when `load_n` is low, `ce_a_n` is low, `ce_b` is high and `ce_c_n` is low. `wr_n` low makes it a write and `wr_n` high makes it a read. With `load_n` low and any chip enable inactive, the slot is a deselect.
- R3: For a write whose address is sampled at enabled edge k, `wdata` is sampled at enabled edge k+2, and that edge completes the write. `bus_drive` is low between edges k+1 and k+2 whatever `oe_n` is.
- R4: For a read whose address is sampled at enabled edge k, `rdata` holds the addressed word after edge k+1, and `bus_drive` then equals the inverse of `oe_n`.
- R5: `lane_wr_n[i]` low writes lane i, which is bits [9i+8:9i] of the word. A lane whose select is high keeps its old contents.
- R6: After a deselect sampled at enabled edge k, `bus_drive` is low from edge k+1 on. After leaving the deselected state, the cycle that follows the first access edge never drives.
- R7: A read or a write may be issued at every enabled edge, in any mix, with no idle slots.
- R8: A read whose address matches a write whose data has not yet been stored returns that write's data in the lanes the write selects and the stored contents in the other lanes.
- R9: With `load_n` high after an access, the next beat runs at the address on `addr` with the access type of the burst, and the chip enables and `wr_n` are ignored. After a deselect, `load_n` high issues nothing.
- R10: Synchronous reset (`rst_n` low) clears `bus_drive`, the burst state and all pending writes. A write still waiting for its data when reset is taken never reaches the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the whole block |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| load_n | input | 1 | Low: start a new access; high: continue the burst |
| wr_n | input | 1 | Low selects a write, high a read (new accesses only) |
| lane_wr_n | input | 4 | Per-lane write selects, active low |
| addr | input | 8 | Word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Registered read data |
| bus_drive | output | 1 | High when the block drives the shared data bus |

## Verification
The hardest situation to reach from the ports is a read whose output edge is the same edge that brings in the data of an earlier write to the same word. Only a partial lane mask shows whether the bypass merges lane by lane, and a stall inside the window shows whether the pairing survives. Directed tasks build this case on purpose: a write followed at once by a read of its address, a partial-lane variant, and a variant with stalls between the address and data edges. A long mixed run then confines addresses to sixteen words, so writes, reads, bursts, deselects and stalls hit the same locations again and again.

// File: rtl/nbl_pkg.sv
package nbl_pkg;
  // Kind of operation held in one pipeline slot
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/nbl_cmd_decode.sv
module nbl_cmd_decode
  import nbl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic ce_a_n,
  input  logic ce_b,
  input  logic ce_c_n,
  input  logic load_n,
  input  logic wr_n,
  output op_e  op
);
  logic burst_on;
  logic burst_wr;
  logic sel;

  assign sel = ~ce_a_n & ce_b & ~ce_c_n;

  always_comb begin
    if (!load_n)
      op = sel ? (wr_n ? OP_READ : OP_WRITE) : OP_NONE;
    else if (burst_on)
      op = burst_wr ? OP_WRITE : OP_READ;
    else
      op = OP_NONE;
  end

  // The burst keeps the type of the access that opened it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_on <= 1'b0;
      burst_wr <= 1'b0;
    end else if (adv) begin
      burst_on <= (op != OP_NONE);
      burst_wr <= (op == OP_WRITE);
    end
  end
endmodule

// File: rtl/nbl_ctl_pipe.sv
module nbl_ctl_pipe
  import nbl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_lane_n,
  output op_e               head_op,
  output logic [ADDR_W-1:0] head_addr,
  output op_e               tail_op,
  output logic [ADDR_W-1:0] tail_addr,
  output logic [LANES-1:0]  tail_lanes
);
  localparam int LAST = STAGES - 1;

  op_e               st_op    [STAGES];
  logic [ADDR_W-1:0] st_addr  [STAGES];
  logic [LANES-1:0]  st_lanes [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_op[i] <= OP_NONE;
    end else if (adv) begin
      st_op[0]    <= in_op;
      st_addr[0]  <= in_addr;
      st_lanes[0] <= ~in_lane_n;
      for (int i = 1; i < STAGES; i++) begin
        st_op[i]    <= st_op[i-1];
        st_addr[i]  <= st_addr[i-1];
        st_lanes[i] <= st_lanes[i-1];
      end
    end
  end

  assign head_op    = st_op[0];
  assign head_addr  = st_addr[0];
  assign tail_op    = st_op[LAST];
  assign tail_addr  = st_addr[LAST];
  assign tail_lanes = st_lanes[LAST];
endmodule

// File: rtl/nbl_store.sv
module nbl_store #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     adv,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [LANES-1:0]         wr_lanes,
  input  logic [LANES*LANE_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [LANES*LANE_W-1:0]  rd_word
);
  localparam int WORDS = 1 << ADDR_W;

  logic same_word;
  assign same_word = wr_en & (wr_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [WORDS];
    logic              take_new;

    always_ff @(posedge clk) begin
      if (adv && wr_en && wr_lanes[g])
        cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    // Data committing on this very edge is forwarded lane by lane
    assign take_new = same_word & wr_lanes[g];
    assign rd_word[g*LANE_W +: LANE_W] =
      take_new ? wr_data[g*LANE_W +: LANE_W] : cells[rd_addr];
  end
endmodule

// File: rtl/nbl_sram.sv
module nbl_sram
  import nbl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en_n,
  input  logic                     ce_a_n,
  input  logic                     ce_b,
  input  logic                     ce_c_n,
  input  logic                     load_n,
  input  logic                     wr_n,
  input  logic [LANES-1:0]         lane_wr_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  wdata,
  input  logic                     oe_n,
  output logic [LANES*LANE_W-1:0]  rdata,
  output logic                     bus_drive
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int WR_LAG = 2;

  logic              adv;
  op_e               cur_op;
  op_e               rd_op;
  op_e               cm_op;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] cm_addr;
  logic [LANES-1:0]  cm_lanes;
  logic              cm_wr;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q;
  logic              drive_q;

  assign adv = ~clk_en_n;

  nbl_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .load_n(load_n), .wr_n(wr_n), .op(cur_op)
  );

  nbl_ctl_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .STAGES(WR_LAG)) u_pipe (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .in_op(cur_op), .in_addr(addr), .in_lane_n(lane_wr_n),
    .head_op(rd_op), .head_addr(rd_addr),
    .tail_op(cm_op), .tail_addr(cm_addr), .tail_lanes(cm_lanes)
  );

  // A reset edge drops the write that would have committed on it
  assign cm_wr = rst_n & (cm_op == OP_WRITE);

  nbl_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .adv(adv), .wr_en(cm_wr), .wr_addr(cm_addr),
    .wr_lanes(cm_lanes), .wr_data(wdata), .rd_addr(rd_addr),
    .rd_word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
    end else if (adv) begin
      drive_q <= (rd_op == OP_READ);
      if (rd_op == OP_READ) rdata_q <= rd_word;
    end
  end

  assign rdata     = rdata_q;
  assign bus_drive = drive_q & ~oe_n;
endmodule

// File: rtl/nbl_sram_chk.sv
module nbl_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              ce_a_n,
  input logic              ce_b,
  input logic              ce_c_n,
  input logic              load_n,
  input logic              wr_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] rdata,
  input logic              bus_drive
);
  logic sel;
  logic start_rd;
  logic start_wr;
  logic start_off;

  assign sel       = ~ce_a_n & ce_b & ~ce_c_n;
  assign start_rd  = ~clk_en_n & ~load_n & sel & wr_n;
  assign start_wr  = ~clk_en_n & ~load_n & sel & ~wr_n;
  assign start_off = ~clk_en_n & ~load_n & ~sel;

  a_r1_stall_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(rdata));

  a_r3_write_data_phase_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr ##1 !clk_en_n |=> !bus_drive);

  a_r4_read_drives_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd ##1 !clk_en_n |=> (bus_drive == !oe_n));

  a_r6_deselect_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
    start_off ##1 !clk_en_n |=> !bus_drive);

  a_r9_burst_read_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd ##1 (!clk_en_n && load_n) ##1 !clk_en_n |=> (bus_drive == !oe_n));

  a_r10_reset_releases_bus: assert property (@(posedge clk)
    !rst_n |=> !bus_drive);
endmodule

bind nbl_sram nbl_sram_chk u_chk (.*);

// File: tb/test_nbl_sram.sv
module test_nbl_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en_n = 1'b1;
  logic        ce_a_n = 1'b1;
  logic        ce_b = 1'b0;
  logic        ce_c_n = 1'b1;
  logic        load_n = 1'b0;
  logic        wr_n = 1'b1;
  logic [3:0]  lane_wr_n = 4'hf;
  logic [7:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic        oe_n = 1'b0;
  logic [35:0] rdata;
  logic        bus_drive;

  int checks = 0;
  int errors = 0;

  // Reference model, built from the requirements
  logic [35:0] ref_mem [256];
  int          m_op   [2];
  logic [7:0]  m_addr [2];
  logic [3:0]  m_lane [2];
  logic [35:0] m_d    [2];
  logic        exp_q = 1'b0;
  logic        have_rd = 1'b0;
  logic [35:0] exp_rd = '0;
  logic        b_on = 1'b0;
  int          b_kind = 0;

  localparam logic [2:0] SEL = 3'b010;  // {ce_a_n, ce_b, ce_c_n}

  nbl_sram i_nbl_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .load_n(load_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .bus_drive(bus_drive)
  );

  always #5 clk = ~clk;

  function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] ln);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (ln[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  function automatic logic [35:0] pat(logic [7:0] a, logic [7:0] s);
    return {a[3:0], a ^ s, ~a, s, a + 8'd3};
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 2; i++) m_op[i] = 0;
    exp_q = 1'b0;
    b_on = 1'b0;
  endtask

  // One clock: present inputs, take the edge, update the model, check
  task automatic tick(input logic cen, input logic [2:0] ce, input logic ld_n,
                      input logic w_n, input logic [3:0] ln_n, input logic [7:0] a,
                      input logic [35:0] d, input logic oen, input string tag);
    logic sel;
    int   k;
    clk_en_n = cen; {ce_a_n, ce_b, ce_c_n} = ce; load_n = ld_n; wr_n = w_n;
    lane_wr_n = ln_n; addr = a; oe_n = oen; wdata = m_d[1];
    @(posedge clk);
    if (!cen) begin
      if (m_op[1] == 2) ref_mem[m_addr[1]] = merge(ref_mem[m_addr[1]], m_d[1], m_lane[1]);
      if (m_op[0] == 1) begin
        exp_rd = ref_mem[m_addr[0]]; exp_q = 1'b1; have_rd = 1'b1;
      end else exp_q = 1'b0;
      sel = ~ce[2] & ce[1] & ~ce[0];
      if (!ld_n) k = sel ? (w_n ? 1 : 2) : 0;
      else       k = b_on ? b_kind : 0;
      b_on = (k != 0); b_kind = k;
      m_op[1] = m_op[0]; m_addr[1] = m_addr[0]; m_lane[1] = m_lane[0]; m_d[1] = m_d[0];
      m_op[0] = k; m_addr[0] = a; m_lane[0] = ~ln_n; m_d[0] = d;
    end
    #1;
    check(bus_drive === (exp_q & ~oen), tag, "bus_drive", 36'(bus_drive), 36'(exp_q & ~oen));
    if (have_rd) check(rdata === exp_rd, tag, "rdata", rdata, exp_rd);
  endtask

  task automatic wr(input logic [7:0] a, input logic [35:0] d, input logic [3:0] ln_n, input string tag);
    tick(1'b0, SEL, 1'b0, 1'b0, ln_n, a, d, 1'b0, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    tick(1'b0, SEL, 1'b0, 1'b1, 4'hf, a, '0, 1'b0, tag);
  endtask
  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 3'b110, 1'b0, 1'b1, 4'hf, 8'h00, '0, 1'b0, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; oe_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(bus_drive === 1'b0, "R10", "bus_drive in reset", 36'(bus_drive), 36'h0);
    model_clear();
    rst_n = 1'b1;
  endtask

  task automatic t_fill();
    for (int a = 0; a < 256; a++) wr(8'(a), pat(8'(a), 8'h5a), 4'h0, "R3");
    idle(2, "R3");
  endtask

  task automatic t_single();
    wr(8'h10, 36'h123456789, 4'h0, "R3");
    idle(3, "R3");
    rd(8'h10, "R4");
    idle(2, "R4");
    tick(1'b0, SEL, 1'b0, 1'b1, 4'hf, 8'h11, '0, 1'b1, "R4");  // oe_n high
    tick(1'b0, 3'b110, 1'b0, 1'b1, 4'hf, 8'h00, '0, 1'b1, "R4");
    tick(1'b0, 3'b110, 1'b0, 1'b1, 4'hf, 8'h00, '0, 1'b0, "R4");
  endtask

  task automatic t_lanes();
    wr(8'h20, 36'hfffffffff, 4'b1010, "R5");  // lanes 0 and 2 only
    idle(2, "R5");
    rd(8'h20, "R5");
    wr(8'h21, 36'h000000000, 4'b0111, "R5");  // lane 3 only
    idle(2, "R5");
    rd(8'h21, "R5");
    idle(2, "R5");
  endtask

  task automatic t_alternate();
    for (int i = 0; i < 8; i++) begin
      wr(8'(8'h30 + i), pat(8'(i), 8'hc3), 4'(i), "R7");
      rd(8'(8'h40 + i), "R7");
    end
    for (int i = 0; i < 8; i++) rd(8'(8'h30 + i), "R7");
    idle(2, "R7");
  endtask

  task automatic t_coherent();
    wr(8'h50, 36'habcdef012, 4'h0, "R8");
    rd(8'h50, "R8");                          // data arrives on the read's output edge
    wr(8'h51, 36'h111111111, 4'b0101, "R8");  // partial lanes
    rd(8'h51, "R8");
    wr(8'h52, 36'h222222222, 4'h0, "R8");
    idle(1, "R8");
    rd(8'h52, "R8");
    wr(8'h53, 36'h333333333, 4'b1001, "R8");  // stall inside the window
    tick(1'b1, 3'b110, 1'b0, 1'b1, 4'hf, 8'h00, '0, 1'b0, "R8");
    rd(8'h53, "R8");
    tick(1'b1, 3'b110, 1'b0, 1'b1, 4'hf, 8'h00, '0, 1'b0, "R8");
    idle(3, "R8");
  endtask

  task automatic t_deselect();
    rd(8'h10, "R6");
    idle(1, "R6");                            // deselect: read still drives once
    idle(2, "R6");
    tick(1'b0, 3'b110, 1'b0, 1'b1, 4'hf, 8'h12, '0, 1'b0, "R2");  // ce_a_n inactive
    tick(1'b0, 3'b000, 1'b0, 1'b1, 4'hf, 8'h12, '0, 1'b0, "R2");  // ce_b inactive
    tick(1'b0, 3'b011, 1'b0, 1'b1, 4'hf, 8'h12, '0, 1'b0, "R2");  // ce_c_n inactive
    tick(1'b0, 3'b110, 1'b0, 1'b0, 4'h0, 8'h12, 36'h0, 1'b0, "R2"); // deselected write
    idle(2, "R2");
    tick(1'b0, 3'b110, 1'b1, 1'b1, 4'hf, 8'h13, '0, 1'b0, "R9");  // load_n high after deselect
    idle(2, "R9");
    rd(8'h12, "R2");
    idle(2, "R2");
  endtask

  task automatic t_stall();
    rd(8'h11, "R1");
    for (int i = 0; i < 3; i++) tick(1'b1, SEL, 1'b0, 1'b0, 4'h0, 8'h11, 36'h0, 1'b0, "R1");
    idle(1, "R1");
    wr(8'h60, 36'h5a5a5a5a5, 4'h0, "R1");
    tick(1'b0, 3'b110, 1'b0, 1'b1, 4'hf, 8'h00, '0, 1'b0, "R1");
    for (int i = 0; i < 4; i++) tick(1'b1, 3'b110, 1'b0, 1'b1, 4'hf, 8'h00, '0, 1'b0, "R1");
    idle(2, "R1");
    rd(8'h60, "R1");
    idle(2, "R1");
  endtask

  task automatic t_burst();
    rd(8'h70, "R9");
    tick(1'b0, 3'b110, 1'b1, 1'b0, 4'h0, 8'h71, '0, 1'b0, "R9");  // ce and wr_n ignored
    tick(1'b0, 3'b000, 1'b1, 1'b0, 4'h0, 8'h72, '0, 1'b0, "R9");
    tick(1'b0, 3'b110, 1'b1, 1'b1, 4'hf, 8'h73, '0, 1'b0, "R9");
    wr(8'h80, 36'h0f0f0f0f0, 4'h0, "R9");
    tick(1'b0, 3'b110, 1'b1, 1'b1, 4'h0, 8'h81, 36'h1e1e1e1e1, 1'b0, "R9");
    tick(1'b0, 3'b011, 1'b1, 1'b1, 4'b1100, 8'h82, 36'h2d2d2d2d2, 1'b0, "R9");
    idle(3, "R9");
    for (int i = 0; i < 3; i++) rd(8'(8'h80 + i), "R9");
    idle(2, "R9");
  endtask

  task automatic t_reset_flush();
    wr(8'h90, 36'hdeadbeef1, 4'h0, "R10");
    tick(1'b0, 3'b110, 1'b0, 1'b1, 4'hf, 8'h00, '0, 1'b0, "R10");
    t_reset();                                 // drops the waiting write
    idle(2, "R10");
    rd(8'h90, "R10");
    idle(2, "R10");
  endtask

  task automatic t_random();
    for (int i = 0; i < 3000; i++) begin
      int          r = $urandom_range(0, 99);
      logic [7:0]  a = 8'($urandom_range(0, 15));
      logic [35:0] d = {4'($urandom), 32'($urandom)};
      logic [3:0]  l = 4'($urandom);
      logic        o = ($urandom_range(0, 9) == 0);
      if (r < 12)      tick(1'b1, 3'($urandom), 1'($urandom), 1'($urandom), l, a, d, o, "R8");
      else if (r < 24) tick(1'b0, 3'b110, 1'b0, 1'($urandom), l, a, d, o, "R8");
      else if (r < 42) tick(1'b0, 3'($urandom), 1'b1, 1'($urandom), l, a, d, o, "R8");
      else if (r < 71) tick(1'b0, SEL, 1'b0, 1'b0, l, a, d, o, "R8");
      else             tick(1'b0, SEL, 1'b0, 1'b1, l, a, d, o, "R8");
    end
    idle(3, "R8");
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin m_op[i] = 0; m_addr[i] = '0; m_lane[i] = '0; m_d[i] = '0; end
    void'($urandom(7));
    @(negedge clk);
    t_reset();
    t_fill();
    t_single();
    t_lanes();
    t_alternate();
    t_coherent();
    t_deselect();
    t_stall();
    t_burst();
    t_reset_flush();
    t_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule